// File: doc/BRIEF.md
# Serial-bus ROM read responder

This block is a read-only program store that sits on a single-wire serial bus. It shares one line, ISA, with a processor and with other memory devices. Time on the bus is split into 56-bit cycles. In every cycle the processor shifts a 16-bit address out on ISA during one fixed phase window. If the top nibble of that address matches the block's page, the block shifts the 10-bit stored word back onto ISA during a later window of the same cycle. The block drives the line only through an output enable, so it releases ISA at every other time.

The processor raises SYNC while an instruction word is on the line. The block watches every word returned with SYNC high, whichever device sent it. When that word is the fetch-data opcode, the block treats the next cycle as a data read: SYNC stays low in that cycle and the returned word is data, not an instruction. Instruction fetches from a small input/output window of the page return a no-operation word, while data reads of that window return the stored content.

A simple write port fills the store. A write takes the single memory port in the cycle it lands, and the read for that cycle moves two bits later, so an instruction fetched right after a write still gets the correct word.

Top module: `srr_responder`

## Requirements
- R1: While reset is asserted, `isa_oe_o` is low. After reset, `isa_oe_o` is high only in phases 46 to 55 of a cycle whose address selects this page. `isa_o` is 0 whenever `isa_oe_o` is low.
- R2: The address is taken from ISA in phases 16 to 31, least significant bit first. The page is selected when address bits 15:12 equal `PAGE`. Only the low `OFS_W` address bits index the store; address bits 11 down to `OFS_W` are ignored.
- R3: On a selected cycle, the word is driven on `isa_o` least significant bit first. Bit k appears in phase 46+k, for k = 0 to 9.
- R4: The phase counter runs from 0 to 55 and wraps. When SYNC is sampled high and then low, the bit sampled low is phase 0. A misaligned device is therefore aligned again after the next instruction cycle.
- R5: If the word on ISA in phases 46 to 55 equals `FD_OP` (default 10'h330) while SYNC is high, the next cycle is a data cycle. This holds whether this device or another device drove the word.
- R6: When an instruction is fetched (not in a data cycle) from an offset in `IO_LO` to `IO_HI` (default 6'h38 to 6'h3F), the block returns 10'h000. Offsets just outside that range return the stored word.
- R7: A data-cycle read of an offset inside `IO_LO` to `IO_HI` returns the stored word.
- R8: If `wr_en_i` is high when phase 32 is sampled, `wr_word_i` is written at offset `wr_ofs_i`. The read of that cycle is then taken at phase 34 and returns the contents after the write, including when the write and the read use the same offset.
- R9: If `FD_OP` is returned during a data cycle (SYNC low), the following cycle is not a data cycle.
- R10: A data cycle returns the word stored at the offset of the address presented on ISA in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one period per bus phase |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sync_i | input | 1 | SYNC line from the processor, high while an instruction word is on ISA |
| isa_i | input | 1 | Sampled level of the shared ISA line |
| wr_en_i | input | 1 | Write request, taken at phase 32 |
| wr_ofs_i | input | OFS_W | Store offset to write |
| wr_word_i | input | 10 | Word to write |
| isa_o | output | 1 | Bit driven onto ISA when enabled |
| isa_oe_o | output | 1 | Output enable for ISA |

## Verification
The assertions check four things on every clock. The enable is high only inside the return window and always rises at its first phase. A falling SYNC puts the counter back to phase 1 on the next bit. Every write is followed two bits later by the deferred read. The data-cycle flag rises only after an edge on which SYNC was high. Which word is returned cannot be seen by a property, so only the bench scenarios show it: page decoding and offset aliasing, no-operation substitution in the input/output window and its two boundaries, data cycles set up by this device or by another device, a fetch-data opcode that comes back as data, read-after-write to the same offset, and recovery after a bit slip.

// File: rtl/srr_pkg.sv
package srr_pkg;
  localparam int BUS_ADDR_W = 16;
  localparam int BUS_WORD_W = 10;
  localparam int PH_W       = 6;

  typedef logic [PH_W-1:0] phase_t;

  // Phase windows on the shared line
  localparam phase_t LAST_PH    = 6'd55;
  localparam phase_t ADDR_LO    = 6'd16;
  localparam phase_t ADDR_HI    = ADDR_LO + phase_t'(BUS_ADDR_W - 1);
  localparam phase_t RET_LO     = 6'd46;
  localparam phase_t RET_HI     = RET_LO + phase_t'(BUS_WORD_W - 1);
  // Store access points: normal read, or write then deferred read
  localparam phase_t RD_PH      = 6'd32;
  localparam phase_t RD_LATE_PH = 6'd34;
endpackage

// File: rtl/srr_phase.sv
module srr_phase
  import srr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sync_i,
  output phase_t ph_o,
  output phase_t eff_o
);
  logic   sync_d;
  logic   fall;
  phase_t ph_q, ph_d;

  assign fall  = sync_d & ~sync_i;
  // The bit being sampled on a SYNC fall is phase 0 by definition
  assign eff_o = fall ? '0 : ph_q;
  assign ph_o  = ph_q;

  always_comb begin
    if (fall)                 ph_d = 6'd1;
    else if (eff_o == LAST_PH) ph_d = '0;
    else                       ph_d = eff_o + 6'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      sync_d <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      sync_d <= sync_i;
    end
  end
endmodule

// File: rtl/srr_capture.sv
module srr_capture
  import srr_pkg::*;
#(
  parameter logic [BUS_WORD_W-1:0] FD_OP = 10'h330
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sync_i,
  input  logic                  isa_i,
  input  phase_t                eff_i,
  output logic [BUS_ADDR_W-1:0] addr_o,
  output logic                  fd_o
);
  logic [BUS_ADDR_W-1:0] addr_q, addr_d;
  logic [BUS_WORD_W-1:0] op_q, op_d;
  logic                  fd_q, fd_d;
  logic                  addr_en, op_en, op_last;

  assign addr_en = (eff_i >= ADDR_LO) && (eff_i <= ADDR_HI);
  assign op_en   = (eff_i >= RET_LO) && (eff_i <= RET_HI);
  assign op_last = (eff_i == RET_HI);

  always_comb begin
    addr_d = addr_q;
    op_d   = op_q;
    fd_d   = fd_q;
    if (addr_en) addr_d = {isa_i, addr_q[BUS_ADDR_W-1:1]};
    if (op_en)   op_d   = {isa_i, op_q[BUS_WORD_W-1:1]};
    // Snooped word decides whether the coming cycle carries data
    if (op_last) fd_d   = sync_i && (op_d == FD_OP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      op_q   <= '0;
      fd_q   <= 1'b0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (op_en)   op_q   <= op_d;
      if (op_last) fd_q   <= fd_d;
    end
  end

  assign addr_o = addr_q;
  assign fd_o   = fd_q;
endmodule

// File: rtl/srr_store.sv
module srr_store
  import srr_pkg::*;
#(
  parameter int                 OFS_W = 6,
  parameter logic [3:0]         PAGE  = 4'hB,
  parameter logic [OFS_W-1:0]   IO_LO = 6'h38,
  parameter logic [OFS_W-1:0]   IO_HI = 6'h3F
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  phase_t                eff_i,
  input  logic [BUS_ADDR_W-1:0] addr_i,
  input  logic                  fd_i,
  input  logic                  wr_en_i,
  input  logic [OFS_W-1:0]      wr_ofs_i,
  input  logic [BUS_WORD_W-1:0] wr_word_i,
  output logic [BUS_WORD_W-1:0] word_o,
  output logic                  hit_o,
  output logic                  wr_fire_o,
  output logic                  rd_fire_o
);
  localparam int DEPTH = 1 << OFS_W;

  logic [BUS_WORD_W-1:0] mem [DEPTH];
  logic [BUS_WORD_W-1:0] word_q, word_d, rd_val;
  logic                  hit_q, hit_d;
  logic                  pend_q, pend_d;
  logic [OFS_W-1:0]      ofs;
  logic                  in_io, sel;
  logic                  addr_unused;

  assign ofs         = addr_i[OFS_W-1:0];
  assign addr_unused = ^addr_i[BUS_ADDR_W-5:OFS_W];
  assign sel         = (addr_i[BUS_ADDR_W-1:BUS_ADDR_W-4] == PAGE);
  assign in_io       = (ofs >= IO_LO) && (ofs <= IO_HI);

  // One port: a write claims phase 32, the read slips to phase 34
  assign wr_fire_o = (eff_i == RD_PH) && wr_en_i;
  assign rd_fire_o = ((eff_i == RD_PH) && !wr_en_i) ||
                     ((eff_i == RD_LATE_PH) && pend_q);

  always_comb begin
    rd_val = (in_io && !fd_i) ? '0 : mem[ofs];
    word_d = word_q;
    hit_d  = hit_q;
    pend_d = pend_q;
    if (wr_fire_o) pend_d = 1'b1;
    if (rd_fire_o) begin
      word_d = rd_val;
      hit_d  = sel;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      hit_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      word_q <= word_d;
      hit_q  <= hit_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire_o) mem[wr_ofs_i] <= wr_word_i;
  end

  assign word_o = word_q;
  assign hit_o  = hit_q;
endmodule

// File: rtl/srr_responder.sv
module srr_responder
  import srr_pkg::*;
#(
  parameter int                      OFS_W = 6,
  parameter logic [3:0]              PAGE  = 4'hB,
  parameter logic [OFS_W-1:0]        IO_LO = 6'h38,
  parameter logic [OFS_W-1:0]        IO_HI = 6'h3F,
  parameter logic [BUS_WORD_W-1:0]   FD_OP = 10'h330
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sync_i,
  input  logic                  isa_i,
  input  logic                  wr_en_i,
  input  logic [OFS_W-1:0]      wr_ofs_i,
  input  logic [BUS_WORD_W-1:0] wr_word_i,
  output logic                  isa_o,
  output logic                  isa_oe_o
);
  phase_t                ph_q, eff;
  logic [BUS_ADDR_W-1:0] addr;
  logic                  fd_q;
  logic [BUS_WORD_W-1:0] word_q;
  logic                  hit_q;
  logic                  wr_fire, rd_fire;
  logic [3:0]            bsel;
  logic                  in_ret;

  srr_phase u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (sync_i),
    .ph_o   (ph_q),
    .eff_o  (eff)
  );

  srr_capture #(.FD_OP(FD_OP)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (sync_i),
    .isa_i  (isa_i),
    .eff_i  (eff),
    .addr_o (addr),
    .fd_o   (fd_q)
  );

  srr_store #(
    .OFS_W (OFS_W),
    .PAGE  (PAGE),
    .IO_LO (IO_LO),
    .IO_HI (IO_HI)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .eff_i     (eff),
    .addr_i    (addr),
    .fd_i      (fd_q),
    .wr_en_i   (wr_en_i),
    .wr_ofs_i  (wr_ofs_i),
    .wr_word_i (wr_word_i),
    .word_o    (word_q),
    .hit_o     (hit_q),
    .wr_fire_o (wr_fire),
    .rd_fire_o (rd_fire)
  );

  // Output depends on registered state only, never on the line itself
  assign in_ret   = (ph_q >= RET_LO) && (ph_q <= RET_HI);
  assign bsel     = 4'(ph_q - RET_LO);
  assign isa_oe_o = hit_q && in_ret;
  assign isa_o    = isa_oe_o && word_q[bsel];
endmodule

// File: rtl/srr_responder_chk.sv
module srr_responder_chk
  import srr_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   sync_i,
  input logic   isa_oe,
  input phase_t ph,
  input logic   fd,
  input logic   wr_fire,
  input logic   rd_fire
);
  always_comb begin
    if (!rst_n) assert_oe_low_in_reset_R1: assert (!isa_oe);
  end

  assert_oe_in_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    isa_oe |-> (ph >= RET_LO && ph <= RET_HI));

  assert_oe_starts_at_first_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isa_oe) |-> (ph == RET_LO));

  assert_sync_fall_realigns_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_i) |=> (ph == 6'd1));

  assert_data_flag_needs_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fd) |-> $past(sync_i));

  assert_write_then_late_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> ##1 rd_fire);
endmodule

bind srr_responder srr_responder_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sync_i  (sync_i),
  .isa_oe  (isa_oe_o),
  .ph      (ph_q),
  .fd      (fd_q),
  .wr_fire (wr_fire),
  .rd_fire (rd_fire)
);

// File: tb/srr_responder_tb.sv
module srr_responder_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] PAGE = 4'hB;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync;
  logic       drv;
  logic       wr_en;
  logic [5:0] wr_ofs;
  logic [9:0] wr_word;
  logic       dut_o, dut_oe;
  wire        isa_line = dut_oe ? dut_o : drv;

  int         tests = 0;
  int         fails = 0;
  logic [9:0] mem_m [64];
  bit         fd_m = 1'b0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srr_responder u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_i    (sync),
    .isa_i     (isa_line),
    .wr_en_i   (wr_en),
    .wr_ofs_i  (wr_ofs),
    .wr_word_i (wr_word),
    .isa_o     (dut_o),
    .isa_oe_o  (dut_oe)
  );

  function automatic logic [9:0] pattern(int i);
    return (i == 3) ? 10'h330 : 10'((i * 37 + 9) & 10'h3FF);
  endfunction

  // One 56-bit bus cycle; the bench plays processor and, optionally, another ROM
  task automatic run_cycle(input logic [15:0] addr, input bit instr,
                           input bit other, input logic [9:0] oword,
                           input bit wr, input logic [5:0] wofs, input logic [9:0] wword,
                           input bit cmp, input string tag);
    logic [5:0] ofs;
    bit         sel, io, bad;
    logic [9:0] exp_w, line_w;
    int         bad_p;
    logic       act_oe, act_o, exp_oe, exp_o;
    ofs = addr[5:0];
    sel = (addr[15:12] == PAGE);
    io  = (ofs >= 6'h38);
    if (wr) mem_m[wofs] = wword;
    exp_w  = (io && !fd_m) ? 10'h000 : mem_m[ofs];
    line_w = sel ? exp_w : (other ? oword : 10'h000);
    bad = 1'b0; bad_p = 0;
    act_oe = 1'b0; act_o = 1'b0; exp_oe = 1'b0; exp_o = 1'b0;
    for (int p = 0; p < 56; p++) begin
      @(negedge clk);
      if (cmp && !bad) begin
        exp_oe = sel && (p >= 46);
        exp_o  = exp_oe ? exp_w[(p >= 46) ? p - 46 : 0] : 1'b0;
        if (dut_oe !== exp_oe || dut_o !== exp_o) begin
          bad = 1'b1; bad_p = p; act_oe = dut_oe; act_o = dut_o;
        end
      end
      sync    = instr && (p >= 46);
      drv     = (p >= 16 && p <= 31) ? addr[p - 16] :
                ((p >= 46 && other) ? oword[p - 46] : 1'b0);
      wr_en   = wr;
      wr_ofs  = wofs;
      wr_word = wword;
    end
    fd_m = instr && (line_w == 10'h330);
    if (cmp) begin
      tests++;
      if (bad) begin
        fails++;
        $display("FAIL %s addr=%h phase %0d: actual oe=%b bit=%b, expected oe=%b bit=%b",
                 tag, addr, bad_p, act_oe, act_o, exp_oe, exp_o);
      end
    end
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sync = 1'b0; drv = 1'b0; wr_en = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; sync = 1'b0; drv = 1'b0;
    wr_en = 1'b0; wr_ofs = '0; wr_word = '0;
    repeat (4) @(negedge clk);
    tests++;
    if (dut_oe !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: actual oe=%b, expected 0", dut_oe);
    end
    rst_n = 1'b1;
    // R4: start misaligned by one bit; the SYNC fall realigns
    run_cycle(16'h0000, 1, 0, 10'h0, 0, 6'h0, 10'h0, 0, "R4 align");
    fd_m = 1'b0;
    for (int i = 0; i < 64; i++)
      run_cycle(16'h0000, 1, 0, 10'h0, 1, 6'(i), pattern(i), 1, "R8 R1 load");
    run_cycle(16'hB005, 1, 0, 10'h0, 0, 6'h0, 10'h0, 1, "R3 word");
    run_cycle(16'h3005, 1, 0, 10'h0, 0, 6'h0, 10'h0, 1, "R1 other page");
    run_cycle(16'hBFC5, 1, 0, 10'h0, 0, 6'h0, 10'h0, 1, "R2 alias");
    run_cycle(16'hB03A, 1, 0, 10'h0, 0, 6'h0, 10'h0, 1, "R6 io fetch");
    run_cycle(16'hB003, 1, 0, 10'h0, 0, 6'h0, 10'h0, 1, "R5 own opcode");
    run_cycle(16'hB03A, 0, 0, 10'h0, 0, 6'h0, 10'h0, 1, "R7 R10 io data");
    run_cycle(16'h2000, 1, 1, 10'h330, 0, 6'h0, 10'h0, 1, "R5 other opcode");
    run_cycle(16'hB010, 0, 0, 10'h0, 0, 6'h0, 10'h0, 1, "R10 data");
    run_cycle(16'hB003, 1, 0, 10'h0, 0, 6'h0, 10'h0, 1, "R5 again");
    run_cycle(16'hB003, 0, 0, 10'h0, 0, 6'h0, 10'h0, 1, "R9 opcode as data");
    run_cycle(16'hB03C, 1, 0, 10'h0, 0, 6'h0, 10'h0, 1, "R9 no chained data");
    run_cycle(16'hB020, 1, 0, 10'h0, 1, 6'h20, 10'h2AB, 1, "R8 same offset");
    run_cycle(16'hB021, 1, 0, 10'h0, 1, 6'h22, 10'h155, 1, "R8 other offset");
    run_cycle(16'hB022, 1, 0, 10'h0, 0, 6'h0, 10'h0, 1, "R8 readback");
    // R4: bit slip mid-run, one unchecked cycle, then aligned again
    idle_bits(5);
    run_cycle(16'h0000, 1, 0, 10'h0, 0, 6'h0, 10'h0, 0, "R4 slip");
    fd_m = 1'b0;
    run_cycle(16'hB007, 1, 0, 10'h0, 0, 6'h0, 10'h0, 1, "R4 realigned");
    run_cycle(16'hB03F, 1, 0, 10'h0, 0, 6'h0, 10'h0, 1, "R6 io top");
    run_cycle(16'hB037, 1, 0, 10'h0, 0, 6'h0, 10'h0, 1, "R6 below io");
    run_cycle(16'hB038, 1, 0, 10'h0, 0, 6'h0, 10'h0, 1, "R6 io bottom");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule